// File: doc/BRIEF.md
# Raster Bitmap Sprite Overlay

This block places a single 32x16 monochrome bitmap on a 640x480 video raster. An existing timing generator supplies the horizontal and vertical pixel counters and a video-enable flag. The block does not produce sync pulses. It compares the beam position against a sprite window. The window origin comes from an 8-bit switch bank. Inside the window, the row offset selects a 32-bit word of a built-in combinational bitmap table, and the column offset selects one bit of that word. A set bit lights the pixel in a colour that the same switch bank picks. A clear bit leaves the pixel black.

The origin is quantised so that the sprite always stays inside the visible area. The column origin moves in steps of 32 pixels, and the row origin moves in steps of 16 lines. The red, green and blue outputs are registered on the pixel clock. Each output therefore reflects the counters and switches that were present one clock earlier.

The visible region starts at horizontal count 144 and at line 31. A line is 800 clocks long, and a frame is 521 lines long.

Top module: `sprite_overlay`

## Requirements
- R1: While the active-low reset `rst_n` is low, and on the first clock after it is released, red, green and blue are all 0.
- R2: The window covers counts hc in [144 + 32*sw[3:0], 144 + 32*sw[3:0] + 32) and lines vc in [31 + 16*sw[7:4], 31 + 16*sw[7:4] + 16). The start is inclusive and the end is exclusive.
- R3: For any beam position outside the window, all three colour outputs are 0.
- R4: Let r = vc − row origin and c = hc − column origin. Row r of the bitmap is the table word at address r. Pixel c is bit c of that word, so bit 0 is the leftmost pixel. The bit is 1 when any of these holds: r is 0 or 15, c is 0 or 31, or c equals 2*r.
- R5: A lit pixel is shown in the colour k = sw[7:5], with red = k[2], green = k[1] and blue = k[0]. When k is 0, all three outputs are 1 (white).
- R6: When `video_en` is low, all three outputs are 0, whatever the position and bitmap.
- R7: The outputs change only on the rising clock edge. Each output reflects the inputs sampled at that edge, so the latency is one clock.
- R8: Inside the window, a bitmap bit of 0 gives all three outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hcount | input | 11 | Horizontal pixel counter from the timing generator |
| vcount | input | 11 | Vertical line counter from the timing generator |
| video_en | input | 1 | High while the beam is in the visible region |
| sw | input | 8 | Switch bank: [3:0] column origin, [7:4] row origin, [7:5] colour |
| red | output | 1 | Red output, registered |
| green | output | 1 | Green output, registered |
| blue | output | 1 | Blue output, registered |

## Verification
The bench sweeps a band two pixels wider and one line taller than the window on every side, for 52 switch settings. This band covers the last column and line before the window and the first ones after it. An off-by-one bound would therefore show up as a lit or missing edge pixel. The bitmap border and diagonal catch three kinds of fault: a reversed bit order (the mirrored diagonal would light the wrong pixels), a wrong row address (the rows would shift), and a wrong colour mapping or a missing white substitute for code 0. Separate checks cover three further cases. One holds `video_en` low inside the window, which catches a design that ignores the enable. One compares the outputs just before and just after a clock edge, which catches a design with combinational outputs. One applies lit inputs during reset, which catches a reset that does not clear the outputs.

// File: rtl/sprite_pkg.sv
package sprite_pkg;

    typedef struct packed {
        logic red;
        logic green;
        logic blue;
    } rgb_t;

    // Border frame plus a descending diagonal at column 2*row.
    function automatic logic [63:0] glyph_row(input int row, input int wid, input int hgt);
        logic [63:0] word;
        word = '0;
        for (int c = 0; c < wid; c++) begin
            if (row == 0 || row == hgt - 1 || c == 0 || c == wid - 1 || c == 2 * row)
                word[c] = 1'b1;
        end
        return word;
    endfunction

endpackage

// File: rtl/sprite_rom.sv
module sprite_rom #(
    parameter int SPR_W = 32,
    parameter int SPR_H = 16,
    localparam int ADDR_W = $clog2(SPR_H)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SPR_W-1:0]  word
);
    logic [SPR_W-1:0] table_q [SPR_H];

    for (genvar g = 0; g < SPR_H; g++) begin : g_row
        localparam logic [63:0] ROW_BITS = sprite_pkg::glyph_row(g, SPR_W, SPR_H);
        assign table_q[g] = ROW_BITS[SPR_W-1:0];
    end

    assign word = table_q[addr];
endmodule

// File: rtl/sprite_window.sv
module sprite_window #(
    parameter int CNT_W = 11,
    parameter int SPR_W = 32,
    parameter int SPR_H = 16,
    localparam int PW     = CNT_W + 1,
    localparam int IDX_W  = $clog2(SPR_W),
    localparam int ADDR_W = $clog2(SPR_H)
) (
    input  logic [CNT_W-1:0]  hc,
    input  logic [CNT_W-1:0]  vc,
    input  logic [PW-1:0]     col_org,
    input  logic [PW-1:0]     row_org,
    output logic              active,
    output logic [ADDR_W-1:0] row_addr,
    output logic [IDX_W-1:0]  bit_idx
);
    logic [PW-1:0] hx, vx;
    logic          in_x, in_y;

    always_comb begin
        hx       = {1'b0, hc};
        vx       = {1'b0, vc};
        in_x     = (hx >= col_org) && (hx < col_org + PW'(SPR_W));
        in_y     = (vx >= row_org) && (vx < row_org + PW'(SPR_H));
        active   = in_x && in_y;
        bit_idx  = IDX_W'(hx - col_org);
        row_addr = ADDR_W'(vx - row_org);
    end
endmodule

// File: rtl/sprite_overlay.sv
module sprite_overlay #(
    parameter int CNT_W   = 11,
    parameter int H_START = 144,
    parameter int V_START = 31,
    parameter int SPR_W   = 32,
    parameter int SPR_H   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] hcount,
    input  logic [CNT_W-1:0] vcount,
    input  logic             video_en,
    input  logic [7:0]       sw,
    output logic             red,
    output logic             green,
    output logic             blue
);
    import sprite_pkg::*;

    localparam int PW     = CNT_W + 1;
    localparam int IDX_W  = $clog2(SPR_W);
    localparam int ADDR_W = $clog2(SPR_H);

    logic [PW-1:0]     col_org, row_org;
    logic              active;
    logic [ADDR_W-1:0] row_addr;
    logic [IDX_W-1:0]  bit_idx;
    logic [SPR_W-1:0]  row_word;
    rgb_t              colour;
    rgb_t              rgb_d, rgb_q;

    // Origin is quantised to the sprite size so the window stays on screen.
    always_comb begin
        col_org = PW'(H_START) + PW'(sw[3:0]) * PW'(SPR_W);
        row_org = PW'(V_START) + PW'(sw[7:4]) * PW'(SPR_H);
    end

    sprite_window #(.CNT_W(CNT_W), .SPR_W(SPR_W), .SPR_H(SPR_H)) u_win (
        .hc       (hcount),
        .vc       (vcount),
        .col_org  (col_org),
        .row_org  (row_org),
        .active   (active),
        .row_addr (row_addr),
        .bit_idx  (bit_idx)
    );

    sprite_rom #(.SPR_W(SPR_W), .SPR_H(SPR_H)) u_rom (
        .addr (row_addr),
        .word (row_word)
    );

    always_comb begin
        if (sw[7:5] == 3'b000) colour = '{red: 1'b1, green: 1'b1, blue: 1'b1};
        else                   colour = '{red: sw[7], green: sw[6], blue: sw[5]};
        rgb_d = '0;
        if (video_en && active && row_word[bit_idx])
            rgb_d = colour;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rgb_q <= '0;
        else        rgb_q <= rgb_d;
    end

    assign red   = rgb_q.red;
    assign green = rgb_q.green;
    assign blue  = rgb_q.blue;
endmodule

// File: rtl/sprite_overlay_chk.sv
module sprite_overlay_chk #(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] hcount,
    input logic [CNT_W-1:0] vcount,
    input logic             video_en,
    input logic [7:0]       sw,
    input logic             red,
    input logic             green,
    input logic             blue
);
    logic lit;
    assign lit = red | green | blue;

    assert_reset_dark_R1: assert property (@(posedge clk) !rst_n |=> !lit);

    assert_enable_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !video_en |=> !lit);

    assert_visible_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lit |-> ($past(hcount) >= 11'd144 && $past(hcount) < 11'd784 &&
                 $past(vcount) >= 11'd31  && $past(vcount) < 11'd511));

    assert_column_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lit |-> ({1'b0, $past(hcount)} >= 12'd144 + {3'b0, $past(sw[3:0]), 5'b0} &&
                 {1'b0, $past(hcount)} <  12'd176 + {3'b0, $past(sw[3:0]), 5'b0}));

    assert_colour_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lit |-> ({red, green, blue} == (($past(sw[7:5]) == 3'b000) ? 3'b111 : $past(sw[7:5]))));
endmodule

bind sprite_overlay sprite_overlay_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
    .video_en(video_en), .sw(sw), .red(red), .green(green), .blue(blue)
);

// File: tb/sim_sprite_overlay.sv
`timescale 1ns/1ps
module sim_sprite_overlay;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] hcount = '0;
    logic [10:0] vcount = '0;
    logic        video_en = 1'b0;
    logic [7:0]  sw = '0;
    logic        red, green, blue;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    sprite_overlay u0 (
        .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
        .video_en(video_en), .sw(sw), .red(red), .green(green), .blue(blue)
    );

    function automatic logic [2:0] expect_rgb(int h, int v, bit en, logic [7:0] s);
        int c0, r0, c, r;
        bit on;
        c0 = 144 + 32 * int'(s[3:0]);
        r0 = 31 + 16 * int'(s[7:4]);
        if (!en || h < c0 || h >= c0 + 32 || v < r0 || v >= r0 + 16) return 3'b000;
        c  = h - c0;
        r  = v - r0;
        on = (r == 0) || (r == 15) || (c == 0) || (c == 31) || (c == 2 * r);
        if (!on) return 3'b000;
        return (s[7:5] == 3'b000) ? 3'b111 : s[7:5];
    endfunction

    task automatic check(string tag, logic [2:0] exp);
        checks++;
        if ({red, green, blue} !== exp) begin
            fails++;
            $display("FAIL %s: rgb=%b expected %b (h=%0d v=%0d sw=%h en=%b)",
                     tag, {red, green, blue}, exp, hcount, vcount, sw, video_en);
        end
    endtask

    task automatic apply(int h, int v, bit en, logic [7:0] s);
        @(negedge clk);
        hcount = 11'(h); vcount = 11'(v); video_en = en; sw = s;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R1: lit inputs under reset keep the outputs dark
        apply(144, 31, 1'b1, 8'h00);
        check("R1 reset", 3'b000);
        apply(145, 31, 1'b1, 8'h00);
        check("R1 reset", 3'b000);
        rst_n = 1'b1;
        apply(800, 0, 1'b0, 8'h00);
        check("R1 after release", 3'b000);

        // R7: output follows the inputs one edge later
        @(negedge clk);
        hcount = 11'd144; vcount = 11'd31; video_en = 1'b1; sw = 8'h00;
        #1 check("R7 before edge", 3'b000);
        @(negedge clk);
        check("R7 after edge", 3'b111);

        // R6: enable low inside the window on a lit pixel
        apply(144, 31, 1'b0, 8'h00);
        check("R6 enable low", 3'b000);
        apply(150, 40, 1'b0, 8'hE3);
        check("R6 enable low", 3'b000);

        // R5: every colour code on the top-left corner pixel
        for (int k = 0; k < 8; k++) begin
            logic [7:0] s;
            s = {3'(k), 5'b00000};
            apply(144, 31 + 16 * int'(s[7:4]), 1'b1, s);
            check("R5 colour", (k == 0) ? 3'b111 : 3'(k));
        end

        // R2 R3 R4 R8: sweep a band around the window for many switch settings
        for (int si = 0; si <= 255; si += 5) begin
            logic [7:0] s;
            int c0, r0;
            s  = 8'(si);
            c0 = 144 + 32 * int'(s[3:0]);
            r0 = 31 + 16 * int'(s[7:4]);
            for (int v = r0 - 1; v <= r0 + 16; v++) begin
                for (int h = c0 - 2; h <= c0 + 33; h++) begin
                    logic [2:0] e;
                    string tag;
                    apply(h, v, 1'b1, s);
                    e = expect_rgb(h, v, 1'b1, s);
                    if (h < c0 || h >= c0 + 32 || v < r0 || v >= r0 + 16)
                        tag = (h == c0 - 1 || h == c0 + 32 || v == r0 - 1 || v == r0 + 16) ? "R2 edge" : "R3 outside";
                    else
                        tag = (e == 3'b000) ? "R8 zero bit" : "R4 bitmap";
                    check(tag, e);
                end
            end
        end
        finish_run();
    end
endmodule